// File: doc/BRIEF.md
# External Interrupt Trigger Conditioner

This block sits between a set of external interrupt pins and the chip's interrupt controller. It brings every pin into the clock domain through a synchronizer. It then turns the pin into one active-high request line, according to a per-pin trigger mode. The four modes are low level, high level, falling edge and rising edge.

In the two level modes the request tracks the synchronized pin and holds no memory. Such a request goes away only when the outside source releases the pin. In the two edge modes a detected transition is held in a sticky latch until software clears it through a write-one-to-clear port.

Each pin is governed by a small state machine with three states:

- `PS_LEVEL`: the pin is in a level mode.
- `PS_ARMED`: the pin is in an edge mode and no event is pending.
- `PS_CAPTURED`: the pin is in an edge mode and an event is held.

The transitions are:

- **mode-change**: any state goes to `PS_LEVEL` or `PS_ARMED`, chosen by the new mode.
- **edge-hit**: `PS_ARMED` goes to `PS_CAPTURED`.
- **clear**: `PS_CAPTURED` goes to `PS_ARMED`, but only when no edge arrives in the same cycle.
- **hold**: every other case keeps the current state.

Top module: `ext_irq_cond`

## Requirements
- R1: The mode register holds 2 bits per pin, with pin i at bits [2i+1:2i]. The encodings are 00 low level, 01 high level, 10 falling edge and 11 rising edge. The whole register is loaded from `mode_wr_data` in any cycle where `mode_wr_en` is high.
- R2: After reset every pin is in low-level mode. A pin held high through and after reset raises no request.
- R3: In low-level mode the request equals the inverse of the synchronized pin, and nothing is latched.
- R4: In high-level mode the request equals the synchronized pin, and nothing is latched.
- R5: In falling-edge mode a high-to-low transition of the synchronized pin sets the request, and the request stays set after the pin returns high.
- R6: In rising-edge mode a low-to-high transition of the synchronized pin sets the request, and the request stays set after the pin returns low.
- R7: A cycle with `clr_wr_en` high and bit i of `clr_wr_data` set removes a latched edge request on pin i. The request reads low from the next cycle.
- R8: A clear written to a pin in a level mode has no effect on its request.
- R9: If a new edge is detected in the same cycle that a clear for that pin is written, the latch stays set.
- R10: A mode write that changes a pin's mode empties that pin's latch. A write of the same mode value leaves the latch untouched.
- R11: Each pin passes through two synchronizer flops. In a level mode a pin change shows on the request after the second rising clock edge. In an edge mode it shows after the third.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pin_i | input | NUM_PINS | Asynchronous external interrupt pins |
| mode_wr_en | input | 1 | Load strobe for the mode register |
| mode_wr_data | input | 2*NUM_PINS | New mode value, 2 bits per pin |
| clr_wr_en | input | 1 | Strobe for the write-one-to-clear register |
| clr_wr_data | input | NUM_PINS | Per-pin clear bits; a 1 clears that pin's latch |
| irq_o | output | NUM_PINS | Active-high request per pin to the interrupt controller |

## Verification
The assertions cover the behaviour that can be stated cycle by cycle. Level requests must track the synchronized pin, and a latched edge request must persist until cleared. A clear must drop the request one cycle later unless an edge collides with it, and a collision must keep the request set. A real mode change must empty the latch, and reset must leave every mode at low level.

Some behaviour only the bench's scenarios can show. These are the end-to-end latency through the synchronizer and the detection of each edge direction from real pin waveforms. They also include the absence of a false request with pins held high at reset. Finally, they include the ordering of toggles that shows a latch surviving the pin's return.

// File: rtl/ext_irq_pkg.sv
package ext_irq_pkg;

    // Per-pin trigger mode, 2 bits each
    typedef enum logic [1:0] {
        TRIG_LOW  = 2'b00,
        TRIG_HIGH = 2'b01,
        TRIG_FALL = 2'b10,
        TRIG_RISE = 2'b11
    } trig_mode_e;

    // Per-pin conditioner state
    typedef enum logic [1:0] {
        PS_LEVEL    = 2'b00,
        PS_ARMED    = 2'b01,
        PS_CAPTURED = 2'b10
    } pin_state_e;

endpackage

// File: rtl/ext_irq_sync.sv
module ext_irq_sync #(
    parameter int WIDTH  = 4,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] d_i,
    output logic [WIDTH-1:0] q_o
);
    logic [WIDTH-1:0] chain_q [STAGES];

    for (genvar s = 0; s < STAGES; s++) begin : g_stage
        if (s == 0) begin : g_first
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) chain_q[s] <= '1;
                else        chain_q[s] <= d_i;
            end
        end else begin : g_next
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) chain_q[s] <= '1;
                else        chain_q[s] <= chain_q[s-1];
            end
        end
    end

    assign q_o = chain_q[STAGES-1];
endmodule

// File: rtl/ext_irq_pin_fsm.sv
module ext_irq_pin_fsm
    import ext_irq_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  trig_mode_e mode_i,
    input  trig_mode_e new_mode_i,
    input  logic       mode_chg_i,
    input  logic       level_i,
    input  logic       prev_i,
    input  logic       clr_i,
    output logic       irq_o
);
    pin_state_e state_q, state_d;
    logic       edge_hit;

    always_comb begin
        unique case (mode_i)
            TRIG_RISE: edge_hit = level_i & ~prev_i;
            TRIG_FALL: edge_hit = ~level_i & prev_i;
            default:   edge_hit = 1'b0;
        endcase
    end

    // next-state logic
    always_comb begin
        state_d = state_q;
        if (mode_chg_i) begin
            state_d = new_mode_i[1] ? PS_ARMED : PS_LEVEL;
        end else begin
            unique case (state_q)
                PS_LEVEL:    state_d = PS_LEVEL;
                PS_ARMED:    if (edge_hit) state_d = PS_CAPTURED;
                PS_CAPTURED: if (clr_i && !edge_hit) state_d = PS_ARMED;
                default:     state_d = PS_LEVEL;
            endcase
        end
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= PS_LEVEL;
        else        state_q <= state_d;
    end

    // outputs
    always_comb begin
        unique case (state_q)
            PS_LEVEL:    irq_o = (mode_i == TRIG_HIGH) ? level_i : ~level_i;
            PS_ARMED:    irq_o = 1'b0;
            PS_CAPTURED: irq_o = 1'b1;
            default:     irq_o = 1'b0;
        endcase
    end
endmodule

// File: rtl/ext_irq_cond.sv
module ext_irq_cond
    import ext_irq_pkg::*;
#(
    parameter int NUM_PINS    = 4,
    parameter int SYNC_STAGES = 2
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic [NUM_PINS-1:0]   pin_i,
    input  logic                  mode_wr_en,
    input  logic [2*NUM_PINS-1:0] mode_wr_data,
    input  logic                  clr_wr_en,
    input  logic [NUM_PINS-1:0]   clr_wr_data,
    output logic [NUM_PINS-1:0]   irq_o
);
    localparam int MODE_W = 2 * NUM_PINS;

    logic [MODE_W-1:0]   mode_q;
    logic [NUM_PINS-1:0] pin_sync_w;
    logic [NUM_PINS-1:0] pin_prev_q;

    ext_irq_sync #(.WIDTH(NUM_PINS), .STAGES(SYNC_STAGES)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d_i   (pin_i),
        .q_o   (pin_sync_w)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            mode_q     <= '0;
            pin_prev_q <= '1;
        end else begin
            pin_prev_q <= pin_sync_w;
            if (mode_wr_en) mode_q <= mode_wr_data;
        end
    end

    for (genvar i = 0; i < NUM_PINS; i++) begin : g_pin
        logic chg;
        assign chg = mode_wr_en && (mode_wr_data[2*i+:2] != mode_q[2*i+:2]);

        ext_irq_pin_fsm u_fsm (
            .clk        (clk),
            .rst_n      (rst_n),
            .mode_i     (trig_mode_e'(mode_q[2*i+:2])),
            .new_mode_i (trig_mode_e'(mode_wr_data[2*i+:2])),
            .mode_chg_i (chg),
            .level_i    (pin_sync_w[i]),
            .prev_i     (pin_prev_q[i]),
            .clr_i      (clr_wr_en & clr_wr_data[i]),
            .irq_o      (irq_o[i])
        );
    end
endmodule

// File: rtl/ext_irq_cond_chk.sv
module ext_irq_cond_chk #(
    parameter int NUM_PINS = 4
) (
    input logic                  clk,
    input logic                  rst_n,
    input logic [2*NUM_PINS-1:0] mode_q,
    input logic                  mode_wr_en,
    input logic [2*NUM_PINS-1:0] mode_wr_data,
    input logic                  clr_wr_en,
    input logic [NUM_PINS-1:0]   clr_wr_data,
    input logic [NUM_PINS-1:0]   pin_sync,
    input logic [NUM_PINS-1:0]   pin_prev,
    input logic [NUM_PINS-1:0]   irq_o
);
    // R2: reset leaves every pin in low-level mode
    a_r2_reset_mode: assert property (@(posedge clk) !rst_n |=> mode_q == '0);

    for (genvar k = 0; k < NUM_PINS; k++) begin : g_chk
        logic [1:0] m;
        logic       c, mchg, nedge;
        assign m     = mode_q[2*k+:2];
        assign c     = clr_wr_en & clr_wr_data[k];
        assign mchg  = mode_wr_en && (mode_wr_data[2*k+:2] != m);
        assign nedge = (m == 2'b11) ? (pin_sync[k] & ~pin_prev[k]) :
                       (m == 2'b10) ? (~pin_sync[k] & pin_prev[k]) : 1'b0;

        a_r3_low_follow: assert property (@(posedge clk) disable iff (!rst_n)
            (m == 2'b00) |-> (irq_o[k] == !pin_sync[k]));
        a_r4_high_follow: assert property (@(posedge clk) disable iff (!rst_n)
            (m == 2'b01) |-> (irq_o[k] == pin_sync[k]));
        a_r5_edge_sticky: assert property (@(posedge clk) disable iff (!rst_n)
            (m[1] && irq_o[k] && !c && !mchg) |=> irq_o[k]);
        a_r7_clear: assert property (@(posedge clk) disable iff (!rst_n)
            (m[1] && c && !nedge && !mchg) |=> !irq_o[k]);
        a_r9_edge_wins: assert property (@(posedge clk) disable iff (!rst_n)
            (m[1] && c && nedge && !mchg) |=> irq_o[k]);
        a_r10_mode_clear: assert property (@(posedge clk) disable iff (!rst_n)
            (mchg && mode_wr_data[2*k+1]) |=> !irq_o[k]);
    end
endmodule

bind ext_irq_cond ext_irq_cond_chk #(.NUM_PINS(NUM_PINS)) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .mode_q       (mode_q),
    .mode_wr_en   (mode_wr_en),
    .mode_wr_data (mode_wr_data),
    .clr_wr_en    (clr_wr_en),
    .clr_wr_data  (clr_wr_data),
    .pin_sync     (pin_sync_w),
    .pin_prev     (pin_prev_q),
    .irq_o        (irq_o)
);

// File: tb/sim_ext_irq_cond.sv
`timescale 1ns/1ps
module sim_ext_irq_cond;
    localparam int N = 4;

    logic           clk = 1'b0;
    logic           rst_n = 1'b0;
    logic [N-1:0]   pins = '1;
    logic           mode_wr_en = 1'b0;
    logic [2*N-1:0] mode_wr_data = '0;
    logic           clr_wr_en = 1'b0;
    logic [N-1:0]   clr_wr_data = '0;
    logic [N-1:0]   irq;

    int checks = 0;
    int failures = 0;

    always #5 clk = ~clk;

    ext_irq_cond #(.NUM_PINS(N)) u0 (
        .clk(clk), .rst_n(rst_n), .pin_i(pins),
        .mode_wr_en(mode_wr_en), .mode_wr_data(mode_wr_data),
        .clr_wr_en(clr_wr_en), .clr_wr_data(clr_wr_data),
        .irq_o(irq)
    );

    // vector: {mode[1:0], pin0, clear0, expected irq0}
    localparam logic [4:0] VEC [13] = '{
        5'b00_1_0_0,  // R3 pin high, low-level: no request
        5'b00_0_0_1,  // R3 pin low
        5'b01_0_0_0,  // R4 high-level, pin low
        5'b01_1_0_1,  // R4 pin high
        5'b11_1_0_0,  // R10/R6 switch to rising, no edge
        5'b11_0_0_0,  // R6 falling ignored
        5'b11_1_0_1,  // R6 rising captured
        5'b11_0_0_1,  // R6 sticky, R10 same-mode rewrite
        5'b11_0_1_0,  // R7 clear
        5'b10_0_0_0,  // R10 switch to falling
        5'b10_1_0_0,  // R5 rising ignored
        5'b10_0_0_1,  // R5 falling captured
        5'b10_0_1_0   // R7 clear
    };

    task automatic check(input logic act, input logic exp, input string req);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s: irq=%b expected=%b at %0t", req, act, exp, $time);
        end
    endtask

    task automatic set_modes(input logic [2*N-1:0] m);
        @(negedge clk);
        mode_wr_en = 1'b1; mode_wr_data = m;
        @(negedge clk);
        mode_wr_en = 1'b0;
    endtask

    task automatic pulse_clear(input logic [N-1:0] bits);
        @(negedge clk);
        clr_wr_en = 1'b1; clr_wr_data = bits;
        @(negedge clk);
        clr_wr_en = 1'b0; clr_wr_data = '0;
    endtask

    task automatic settle();
        repeat (4) @(negedge clk);
    endtask

    initial begin : watchdog
        repeat (20000) @(posedge clk);
        failures++;
        $display("FAIL watchdog expired");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin : main
        string tag;
        repeat (3) @(negedge clk);
        check(irq[0], 1'b0, "R2 in reset");
        rst_n = 1'b1;
        settle();
        check(|irq, 1'b0, "R2 after reset, pins high");

        for (int v = 0; v < 13; v++) begin
            @(negedge clk);
            mode_wr_en   = 1'b1;
            mode_wr_data = {6'b0, VEC[v][4:3]};
            pins[0]      = VEC[v][2];
            clr_wr_en    = VEC[v][1];
            clr_wr_data  = 4'b0001;
            @(negedge clk);
            mode_wr_en = 1'b0; clr_wr_en = 1'b0; clr_wr_data = '0;
            settle();
            if (VEC[v][1])               tag = "R7";
            else if (VEC[v][4:3] == 2'b00) tag = "R1/R3";
            else if (VEC[v][4:3] == 2'b01) tag = "R1/R4";
            else if (VEC[v][4:3] == 2'b10) tag = "R1/R5";
            else                          tag = "R1/R6";
            check(irq[0], VEC[v][0], tag);
        end

        // R8: clear on a level-mode pin has no effect
        pins = '1;
        set_modes(8'b00_00_01_00);
        settle();
        check(irq[1], 1'b1, "R4 pin1 high");
        pulse_clear(4'b0010);
        check(irq[1], 1'b1, "R8 clear ignored in level mode");

        // R11: level latency of two edges
        @(negedge clk); pins[1] = 1'b0;
        @(negedge clk); check(irq[1], 1'b1, "R11 level after 1 edge");
        @(negedge clk); check(irq[1], 1'b0, "R11 level after 2 edges");

        // R11: edge latency of three edges (pin2 rising)
        set_modes(8'b00_11_01_00);
        pins[2] = 1'b0;
        settle();
        check(irq[2], 1'b0, "R6 pin2 armed");
        @(negedge clk); pins[2] = 1'b1;
        @(negedge clk); check(irq[2], 1'b0, "R11 edge after 1 edge");
        @(negedge clk); check(irq[2], 1'b0, "R11 edge after 2 edges");
        @(negedge clk); check(irq[2], 1'b1, "R11 edge after 3 edges");

        // R10: mode change drops a held latch
        set_modes(8'b00_10_01_00);
        settle();
        check(irq[2], 1'b0, "R10 mode change clears latch");
        @(negedge clk); pins[2] = 1'b0;
        settle();
        check(irq[2], 1'b1, "R5 pin2 falling captured");
        set_modes(8'b00_10_01_00);
        settle();
        check(irq[2], 1'b1, "R10 same-mode write keeps latch");

        // R9: edge in the same cycle as clear keeps latch
        set_modes(8'b11_10_01_00);
        pins[3] = 1'b0;
        settle();
        @(negedge clk); pins[3] = 1'b1;
        settle();
        check(irq[3], 1'b1, "R6 pin3 rising captured");
        @(negedge clk); pins[3] = 1'b0;
        settle();
        check(irq[3], 1'b1, "R6 pin3 sticky after return low");
        @(negedge clk); pins[3] = 1'b1;
        @(negedge clk);
        @(negedge clk);
        clr_wr_en = 1'b1; clr_wr_data = 4'b1000;
        @(negedge clk);
        clr_wr_en = 1'b0; clr_wr_data = '0;
        repeat (2) @(negedge clk);
        check(irq[3], 1'b1, "R9 edge beats clear");
        pulse_clear(4'b1000);
        check(irq[3], 1'b0, "R7 clear pin3");
        check(irq[2], 1'b1, "R7 clear leaves other pins");

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule